// File: doc/BRIEF.md
# Bounded-Delay Single-Slot Buffer

This block holds exactly one single-bit event and hands it on after a delay that is guaranteed to lie inside a window of clock cycles. The window is bounded below by `LB` and above by `UB`. An event that finds the slot empty is captured. The slot then counts cycles and releases the stored bit as a one-cycle output pulse at a fixed point `EMIT` inside the window. Events that arrive while the slot is occupied are discarded. The slot is never allowed to stay occupied beyond the upper bound.

The top level chains two such slots, each with its own bounds. The first slot's output pulse is the second slot's input event. This arrangement exposes the ordering guarantee: when the first slot's upper bound lies below the second slot's lower bound, the second output can never fire before the first output for the same event. Both slots expose their occupancy flag, so the mode of each stage is visible at the ports.

Top module: `delay_slot_chain`

## Requirements
- R1: While `rst` is high at a rising edge, both stages become empty after that edge: `mid_full`, `fin_full`, `mid_vld`, `fin_vld`, `mid_bit` and `fin_bit` read 0.
- R2: An `ev_vld` sampled at an edge while `mid_full` is 0 and `rst` is 0 makes `mid_full` read 1 after that edge.
- R3: While `mid_full` is 1, `ev_vld` is ignored. The value released later is the bit captured when the slot was entered, whatever bits arrived in between.
- R4: An event accepted at edge k produces `mid_vld` = 1 for exactly one cycle, after edge k+EMIT0+1. During that cycle `mid_bit` carries the captured bit and `mid_full` reads 0. `mid_bit` reads 0 whenever `mid_vld` is 0.
- R5: The release never comes earlier than LB0+1 cycles of occupancy. This means `mid_full` was 1 for at least LB0+1 consecutive cycles before every `mid_vld` pulse, and the same holds for stage two with LB1.
- R6: No stage stays occupied for more than UB+1 consecutive cycles (UB0 for stage one, UB1 for stage two).
- R7: An `ev_vld` presented in the last occupied cycle, the one just before the release pulse, is dropped.
- R8: An `ev_vld` presented during the release pulse cycle is accepted, because the slot is already empty then. This allows back-to-back occupancy.
- R9: Stage two takes `mid_vld`/`mid_bit` as its input. A pulse accepted there at edge k appears as `fin_vld`/`fin_bit` after edge k+EMIT1+1. When UB0 < LB1, every `fin_vld` pulse is preceded, in an earlier cycle, by a `mid_vld` pulse that no earlier `fin_vld` has answered.
- R10: Stage two drops `mid_vld` pulses that arrive while `fin_full` is 1. `fin_vld` implies `fin_full` = 0, and `fin_bit` reads 0 outside pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ev_vld | input | 1 | Input event strobe |
| ev_bit | input | 1 | Input event data bit |
| mid_vld | output | 1 | Stage-one release pulse |
| mid_bit | output | 1 | Stage-one released bit |
| mid_full | output | 1 | Stage-one occupancy flag |
| fin_vld | output | 1 | Stage-two release pulse |
| fin_bit | output | 1 | Stage-two released bit |
| fin_full | output | 1 | Stage-two occupancy flag |

## Verification
The hardest situation to reach is an event that lands in exactly the last occupied cycle, or exactly in the release cycle. One cycle separates a dropped event from an accepted one. The stimulus reaches both cases with a directed sequence that counts cycles from a known capture. A sweep of inter-event gaps from 1 to 14 cycles then drives both stages through every phase relation: continuous flooding, gaps that land inside stage two's occupancy, and gaps that leave both stages idle. A cycle-exact model built from the stated timing predicts all six outputs in every cycle.

// File: rtl/dslot_pkg.sv
package dslot_pkg;

  typedef enum logic {
    SLOT_EMPTY = 1'b0,
    SLOT_FULL  = 1'b1
  } slot_mode_e;

  // counter width able to hold 0 .. ub+1
  function automatic int cnt_width(input int ub);
    return $clog2(ub + 2);
  endfunction

endpackage

// File: rtl/dslot_timer.sv
module dslot_timer #(
  parameter int CW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clear,
  input  logic          run,
  output logic [CW-1:0] count
);

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      count <= '0;
    end else if (run) begin
      count <= count + 1'b1;
    end
  end

endmodule

// File: rtl/dslot_stage.sv
module dslot_stage
  import dslot_pkg::*;
#(
  parameter int LB   = 2,
  parameter int UB   = 4,
  parameter int EMIT = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic in_vld,
  input  logic in_bit,
  output logic out_vld,
  output logic out_bit,
  output logic full
);

  localparam int           CW     = cnt_width(UB);
  localparam logic [CW-1:0] EMIT_C = CW'(EMIT);
  localparam logic [CW-1:0] UB_C   = CW'(UB);

  if ((LB < 0) || (LB > UB) || (EMIT < LB) || (EMIT > UB)) begin : g_bad_bounds
    $error("dslot_stage: bounds must satisfy 0 <= LB <= EMIT <= UB");
  end

  slot_mode_e    mode;
  logic          held;
  logic [CW-1:0] count;
  logic          capture;
  logic          release_now;

  assign capture     = (mode == SLOT_EMPTY) && in_vld;
  // planned release at EMIT; the UB term is the hard deadline backstop
  assign release_now = (mode == SLOT_FULL) && ((count == EMIT_C) || (count >= UB_C));

  dslot_timer #(.CW(CW)) u_timer (
    .clk   (clk),
    .rst   (rst),
    .clear (capture),
    .run   (mode == SLOT_FULL),
    .count (count)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      mode    <= SLOT_EMPTY;
      held    <= 1'b0;
      out_vld <= 1'b0;
      out_bit <= 1'b0;
    end else begin
      out_vld <= release_now;
      out_bit <= release_now & held;
      if (capture) begin
        mode <= SLOT_FULL;
        held <= in_bit;
      end else if (release_now) begin
        mode <= SLOT_EMPTY;
      end
    end
  end

  assign full = (mode == SLOT_FULL);

endmodule

// File: rtl/delay_slot_chain.sv
module delay_slot_chain #(
  parameter int LB0   = 2,
  parameter int UB0   = 4,
  parameter int EMIT0 = 3,
  parameter int LB1   = 6,
  parameter int UB1   = 9,
  parameter int EMIT1 = 7
) (
  input  logic clk,
  input  logic rst,
  input  logic ev_vld,
  input  logic ev_bit,
  output logic mid_vld,
  output logic mid_bit,
  output logic mid_full,
  output logic fin_vld,
  output logic fin_bit,
  output logic fin_full
);

  dslot_stage #(.LB(LB0), .UB(UB0), .EMIT(EMIT0)) u_stage0 (
    .clk     (clk),
    .rst     (rst),
    .in_vld  (ev_vld),
    .in_bit  (ev_bit),
    .out_vld (mid_vld),
    .out_bit (mid_bit),
    .full    (mid_full)
  );

  dslot_stage #(.LB(LB1), .UB(UB1), .EMIT(EMIT1)) u_stage1 (
    .clk     (clk),
    .rst     (rst),
    .in_vld  (mid_vld),
    .in_bit  (mid_bit),
    .out_vld (fin_vld),
    .out_bit (fin_bit),
    .full    (fin_full)
  );

endmodule

// File: rtl/delay_slot_chain_chk.sv
module delay_slot_chain_chk #(
  parameter int LB0 = 2,
  parameter int UB0 = 4,
  parameter int LB1 = 6,
  parameter int UB1 = 9
) (
  input logic clk,
  input logic rst,
  input logic ev_vld,
  input logic mid_vld,
  input logic mid_bit,
  input logic mid_full,
  input logic fin_vld,
  input logic fin_bit,
  input logic fin_full
);

  int unsigned run0;
  int unsigned run1;
  logic        pending;

  always_ff @(posedge clk) begin
    if (rst) begin
      run0    <= 0;
      run1    <= 0;
      pending <= 1'b0;
    end else begin
      run0 <= mid_full ? run0 + 1 : 0;
      run1 <= fin_full ? run1 + 1 : 0;
      if (mid_vld)      pending <= 1'b1;
      else if (fin_vld) pending <= 1'b0;
    end
  end

  p_reset_empty_r1: assert property (@(posedge clk)
    rst |=> (!mid_full && !fin_full && !mid_vld && !fin_vld && !mid_bit && !fin_bit));

  p_capture_r2: assert property (@(posedge clk) disable iff (rst)
    (ev_vld && !mid_full) |=> mid_full);

  p_single_pulse_r4: assert property (@(posedge clk) disable iff (rst)
    mid_vld |=> !mid_vld);

  p_release_empty_r4: assert property (@(posedge clk) disable iff (rst)
    mid_vld |-> !mid_full);

  p_bit_quiet_r4: assert property (@(posedge clk) disable iff (rst)
    !mid_vld |-> !mid_bit);

  p_lower_bound_r5: assert property (@(posedge clk) disable iff (rst)
    mid_vld |-> (run0 >= LB0 + 1));

  p_lower_bound_fin_r5: assert property (@(posedge clk) disable iff (rst)
    fin_vld |-> (run1 >= LB1 + 1));

  p_upper_bound_r6: assert property (@(posedge clk) disable iff (rst)
    run0 <= UB0 + 1);

  p_upper_bound_fin_r6: assert property (@(posedge clk) disable iff (rst)
    run1 <= UB1 + 1);

  p_fin_release_r10: assert property (@(posedge clk) disable iff (rst)
    fin_vld |-> (!fin_full && (run1 >= 1)));

  p_fin_quiet_r10: assert property (@(posedge clk) disable iff (rst)
    !fin_vld |-> !fin_bit);

  if (UB0 < LB1) begin : g_order
    p_order_r9: assert property (@(posedge clk) disable iff (rst)
      fin_vld |-> pending);
  end

endmodule

bind delay_slot_chain delay_slot_chain_chk #(
  .LB0(LB0), .UB0(UB0), .LB1(LB1), .UB1(UB1)
) u_chk (
  .clk      (clk),
  .rst      (rst),
  .ev_vld   (ev_vld),
  .mid_vld  (mid_vld),
  .mid_bit  (mid_bit),
  .mid_full (mid_full),
  .fin_vld  (fin_vld),
  .fin_bit  (fin_bit),
  .fin_full (fin_full)
);

// File: tb/delay_slot_chain_tb.sv
module delay_slot_chain_tb;

  localparam int LB0 = 2, UB0 = 4, E0 = 3;
  localparam int LB1 = 6, UB1 = 9, E1 = 7;
  localparam int MAXS = 8192;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ev_vld = 1'b0;
  logic ev_bit = 1'b0;
  logic mid_vld, mid_bit, mid_full, fin_vld, fin_bit, fin_full;

  delay_slot_chain #(
    .LB0(LB0), .UB0(UB0), .EMIT0(E0), .LB1(LB1), .UB1(UB1), .EMIT1(E1)
  ) u_dut (
    .clk(clk), .rst(rst), .ev_vld(ev_vld), .ev_bit(ev_bit),
    .mid_vld(mid_vld), .mid_bit(mid_bit), .mid_full(mid_full),
    .fin_vld(fin_vld), .fin_bit(fin_bit), .fin_full(fin_full)
  );

  always #10 clk = ~clk;

  bit exp_mv [MAXS];
  bit exp_mb [MAXS];
  bit exp_mf [MAXS];
  bit exp_fv [MAXS];
  bit exp_fb [MAXS];
  bit exp_ff [MAXS];

  int    checks = 0;
  int    failures = 0;
  int    slot = 0;
  int    free0 = 0;
  int    free1 = 0;
  int    run_mid = 0;
  int    cycles = 0;
  bit    done = 1'b0;
  string cur_tag = "R1";

  task automatic check(input string tag, input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s slot=%0d actual=%0b expected=%0b", tag, what, slot, act, exp);
    end
  endtask

  // arithmetic model of accept/release slots from R2, R4, R7, R8, R9, R10
  task automatic model(input int s, input bit b);
    int p;
    int q;
    if (s < free0) return;
    for (int k = s + 1; k <= s + 1 + E0; k++) if (k < MAXS) exp_mf[k] = 1'b1;
    p = s + E0 + 2;
    if (p < MAXS) begin
      exp_mv[p] = 1'b1;
      exp_mb[p] = b;
    end
    free0 = p;
    if (p >= free1) begin
      for (int k = p + 1; k <= p + 1 + E1; k++) if (k < MAXS) exp_ff[k] = 1'b1;
      q = p + E1 + 2;
      if (q < MAXS) begin
        exp_fv[q] = 1'b1;
        exp_fb[q] = b;
      end
      free1 = q;
    end
  endtask

  task automatic compare_slot();
    check(cur_tag, "R2 mid_full", mid_full, exp_mf[slot]);
    check(cur_tag, "R4 mid_vld",  mid_vld,  exp_mv[slot]);
    check(cur_tag, "R3 mid_bit",  mid_bit,  exp_mb[slot]);
    check(cur_tag, "R9 fin_vld",  fin_vld,  exp_fv[slot]);
    check(cur_tag, "R10 fin_bit", fin_bit,  exp_fb[slot]);
    check(cur_tag, "R10 fin_full", fin_full, exp_ff[slot]);
    if (mid_vld) begin
      check(cur_tag, "R5 occupancy>=LB0+1", (run_mid >= LB0 + 1), 1'b1);
      check(cur_tag, "R6 occupancy<=UB0+1", (run_mid <= UB0 + 1), 1'b1);
    end
    run_mid = mid_full ? run_mid + 1 : 0;
  endtask

  // drive one slot (called at a falling edge), advance to the next slot and check it
  task automatic step(input bit v, input bit b);
    ev_vld = v;
    ev_bit = b;
    if (v) model(slot, b);
    @(posedge clk);
    @(negedge clk);
    slot++;
    if (slot < MAXS) compare_slot();
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(1'b0, 1'b0);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int base;
    // R1: reset state
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1", "mid_full", mid_full, 1'b0);
    check("R1", "fin_full", fin_full, 1'b0);
    check("R1", "mid_vld",  mid_vld,  1'b0);
    check("R1", "fin_vld",  fin_vld,  1'b0);
    rst = 1'b0;
    slot = 0;
    compare_slot();

    // R2/R4: single events of each value
    cur_tag = "R2/R4";
    idle(3);
    step(1'b1, 1'b1);
    idle(25);
    step(1'b1, 1'b0);
    idle(25);

    // R7 then R8: event in last full cycle dropped, event in pulse cycle taken
    cur_tag = "R7/R8";
    base = slot;
    step(1'b1, 1'b1);
    idle(E0);
    step(1'b1, 1'b0);
    step(1'b1, 1'b0);
    idle(30);
    if (base < 0) cur_tag = "R7";

    // R3/R10: flood with alternating bits while occupied
    cur_tag = "R3/R10";
    for (int i = 0; i < 40; i++) step(1'b1, i[0]);
    idle(30);

    // R9 and all phases: sweep inter-event gaps
    cur_tag = "R2/R4/R9";
    for (int g = 1; g <= 14; g++) begin
      for (int i = 0; i < 24; i++) begin
        step(1'b1, (((i * 7 + g) >> 1) & 1) == 1);
        idle(g - 1);
      end
      idle(30);
    end

    // R1: reset in the middle of activity empties both stages
    step(1'b1, 1'b1);
    idle(4);
    rst = 1'b1;
    @(posedge clk);
    @(negedge clk);
    check("R1", "mid_full after reset", mid_full, 1'b0);
    check("R1", "fin_full after reset", fin_full, 1'b0);
    check("R1", "mid_vld after reset",  mid_vld,  1'b0);
    check("R1", "fin_vld after reset",  fin_vld,  1'b0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule